// File: doc/BRIEF.md
# Uniform Vector Upload Port

This block sits between a host register write bus and a store of 96 four-component uniform vectors that a shader core reads. The host first writes a setup word that picks the starting slot and the data format. It then streams 32-bit data words at a second address. The block gathers the words of one vector and writes the finished vector into the store. It then moves its slot pointer forward by one, so a block of neighbouring slots needs only one setup write.

Two formats are accepted. The packed format sends four 24-bit values in three words. The single-precision format sends four IEEE 32-bit values, and the block converts each one to the 24-bit storage format. In both formats the last component arrives first. A synchronous read port with one cycle of latency gives the consumer the store contents.

Top module: `vec4_uniform_loader`

## Requirements
- R1: A write with `wr_addr`=0 is a setup write. Its bits 6:0 load the slot pointer and its bit 31 loads the format (0 = packed 24-bit, 1 = single-precision 32-bit).
- R2: In packed format, three data writes (`wr_addr`=1) form one vector. Stored slot bits 31:0 take the first word, bits 63:32 the second and bits 95:64 the third. A slot holds X in bits 95:72, Y in 71:48, Z in 47:24 and W in 23:0.
- R3: In single-precision format, four data words arrive as W, Z, Y, X. Each is converted and placed in its component field.
- R4: The conversion to 24 bits copies the sign and sets the exponent to e-64 (bias 63). The mantissa is input bits 22:7. An input exponent of 64 or less gives a signed zero. An input exponent above 191 gives exponent 127 with the truncated mantissa.
- R5: The slot pointer advances by one only when a vector completes. A partial vector leaves it where it is.
- R6: Data writes continue from the current pointer without a new setup write. A setup write that no data follows changes no slot.
- R7: A setup write discards the words of an unfinished vector.
- R8: While the pointer is above 95, completed vectors are dropped and the pointer holds its value.
- R9: A read returns the slot one cycle after `rd_en`. A read of the slot being written in the same cycle returns the new vector.
- R10: After reset every slot and `rd_data` are zero, the pointer is 0 and the format is packed.
- R11: A read of a slot index above 95 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = setup register, 1 = data register |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_slot | input | 7 | Slot to read |
| rd_data | output | 96 | Slot contents, X in the top field, W in the bottom |

## Verification
Packed vectors use distinct word patterns, so a misplaced byte boundary between Y and Z or between Z and W shows up in one field. Single-precision vectors mix normal values, tiny and huge exponents and a negative infinity, which separates the bias, underflow and saturation paths. Runs that span several slots, a setup write that gets no data, a setup write in the middle of a vector and a pointer past 95 distinguish commit counting from plain word counting. A write and a read of the same slot in one cycle tell the bypass apart from a stale read.

// File: rtl/vec4_uniform_loader.sv
module vec4_uniform_loader #(
  parameter int SLOTS  = 96,
  parameter int IDX_W  = 7,
  parameter int COMP_W = 24,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    rd_slot,
  output logic [4*COMP_W-1:0] rd_data
);
  localparam int VEC_W = 4 * COMP_W;
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

  function automatic logic [23:0] to_f24(input logic [31:0] f);
    logic [7:0] e;
    e = f[30:23];
    if (e <= 8'd64)       return {f[31], 23'd0};
    else if (e > 8'd191)  return {f[31], 7'h7f, f[22:7]};
    else                  return {f[31], 7'(e - 8'd64), f[22:7]};
  endfunction

  logic [IDX_W-1:0]  idx_q;
  logic              mode_q;
  logic [1:0]        wcnt_q;
  logic [WORD_W-1:0] b0_q, b1_q;
  logic [COMP_W-1:0] b2_q;
  logic [VEC_W-1:0]  store [SLOTS];

  logic              cfg_wr, data_wr, commit, in_range;
  logic [COMP_W-1:0] cvt;
  logic [VEC_W-1:0]  commit_val;

  assign cfg_wr   = wr_en & ~wr_addr;
  assign data_wr  = wr_en &  wr_addr;
  assign cvt      = to_f24(wr_data);
  assign commit   = data_wr && (wcnt_q == (mode_q ? 2'd3 : 2'd2));
  assign in_range = idx_q <= LAST_SLOT;
  assign commit_val = mode_q ? {cvt, b2_q, b1_q[COMP_W-1:0], b0_q[COMP_W-1:0]}
                             : {wr_data, b1_q, b0_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      mode_q  <= 1'b0;
      wcnt_q  <= '0;
      b0_q    <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      rd_data <= '0;
      for (int i = 0; i < SLOTS; i++) store[i] <= '0;
    end else begin
      if (cfg_wr) begin
        idx_q  <= wr_data[IDX_W-1:0];
        mode_q <= wr_data[WORD_W-1];
        wcnt_q <= '0;
      end else if (data_wr) begin
        if (commit) begin
          wcnt_q <= '0;
          if (in_range) begin
            store[idx_q] <= commit_val;
            idx_q        <= idx_q + 1'b1;
          end
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
          case (wcnt_q)
            2'd0:    b0_q <= mode_q ? {{(WORD_W-COMP_W){1'b0}}, cvt} : wr_data;
            2'd1:    b1_q <= mode_q ? {{(WORD_W-COMP_W){1'b0}}, cvt} : wr_data;
            default: b2_q <= cvt;
          endcase
        end
      end
      if (rd_en) begin
        if (rd_slot > LAST_SLOT)
          rd_data <= '0;
        else if (commit && in_range && rd_slot == idx_q)
          rd_data <= commit_val;
        else
          rd_data <= store[rd_slot];
      end
    end
  end

  p_cfg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> wcnt_q == 2'd0);

  p_packed_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> wcnt_q != 2'd3);

  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && in_range) |=> idx_q == $past(idx_q) + 1'b1);

  p_partial_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !commit) |=> $stable(idx_q));

  p_overflow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !in_range) |=> $stable(idx_q));

  p_oob_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_slot > LAST_SLOT) |=> rd_data == '0);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/vec4_uniform_loader_bench.sv
module vec4_uniform_loader_bench;
  localparam time CLK = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [6:0]  rd_slot = '0;
  logic [95:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic [95:0] exp_q[$];
  string       tag_q[$];

  always #(CLK/2) clk = ~clk;

  vec4_uniform_loader u_vec4_uniform_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_slot(rd_slot), .rd_data(rd_data)
  );

  function automatic logic [23:0] ref_f24(input logic [31:0] f);
    int e;
    e = int'(f[30:23]) - 64;
    if (e < 1)   return {f[31], 23'd0};
    if (e > 127) return {f[31], 7'd127, f[22:7]};
    return {f[31], e[6:0], f[22:7]};
  endfunction

  function automatic logic [95:0] ref_f32(input logic [31:0] w, z, y, x);
    return {ref_f24(x), ref_f24(y), ref_f24(z), ref_f24(w)};
  endfunction

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [6:0] slot, input logic f32);
    wr(1'b0, {f32, 24'd0, slot});
  endtask

  task automatic rd(input logic [6:0] s, input logic [95:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; rd_slot = s;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wr_rd(input logic [31:0] d, input logic [6:0] s, input logic [95:0] e, input string t);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = d;
    rd_en = 1'b1; rd_slot = s;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rd_en) begin
      logic [95:0] e;
      string t;
      #2;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty actual=%h expected=none", rd_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    #(CLK * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [95:0] v95;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (rd_data !== '0) begin
      failures++;
      $display("FAIL R10 reset rd_data actual=%h expected=0", rd_data);
    end
    rd(7'd0,  '0, "R10 slot0 after reset");
    rd(7'd95, '0, "R10 slot95 after reset");

    // R2/R1: packed vector into slot 3, then next slot without setup (R5/R6)
    setup(7'd3, 1'b0);
    wr(1'b1, 32'h11223344); wr(1'b1, 32'h55667788); wr(1'b1, 32'h99aabbcc);
    rd(7'd3, 96'h99aabbcc_55667788_11223344, "R2 packed slot3");
    wr(1'b1, 32'hdeadbeef); wr(1'b1, 32'h0badf00d); wr(1'b1, 32'hcafe1234);
    rd(7'd4, 96'hcafe1234_0badf00d_deadbeef, "R6 continue slot4");
    // R5: one partial word does not move the pointer or write
    wr(1'b1, 32'h01010101);
    rd(7'd5, '0, "R5 partial leaves slot5");
    // R7: setup in the middle discards the partial word
    setup(7'd5, 1'b0);
    wr(1'b1, 32'ha0a0a0a0); wr(1'b1, 32'hb1b1b1b1); wr(1'b1, 32'hc2c2c2c2);
    rd(7'd5, 96'hc2c2c2c2_b1b1b1b1_a0a0a0a0, "R7 clean vector slot5");
    rd(7'd6, '0, "R7 slot6 untouched");

    // R3/R4: single precision with conversion cases
    setup(7'd20, 1'b1);
    wr(1'b1, 32'h3f800000); wr(1'b1, 32'h40000000); wr(1'b1, 32'hbfc00000); wr(1'b1, 32'h20000000);
    rd(7'd20, 96'h000000_bf8000_400000_3f0000, "R3 f32 slot20");
    wr(1'b1, 32'ha0000000); wr(1'b1, 32'h60000000); wr(1'b1, 32'hff800000); wr(1'b1, 32'h3f812345);
    rd(7'd21, ref_f32(32'ha0000000, 32'h60000000, 32'hff800000, 32'h3f812345), "R4 zero/sat slot21");
    rd(7'd21, 96'h3f0246_ff0000_7f0000_800000, "R4 fixed values slot21");

    // R6: setup with no data writes nothing
    setup(7'd30, 1'b0);
    setup(7'd40, 1'b0);
    wr(1'b1, 32'h00000001); wr(1'b1, 32'h00000002); wr(1'b1, 32'h00000003);
    rd(7'd30, '0, "R6 setup-only slot30");
    rd(7'd40, 96'h00000003_00000002_00000001, "R1 slot40");

    // R8: top slot then overflow drop
    setup(7'd95, 1'b1);
    v95 = ref_f32(32'h3f800000, 32'hc0000000, 32'h41200000, 32'h3e800000);
    wr(1'b1, 32'h3f800000); wr(1'b1, 32'hc0000000); wr(1'b1, 32'h41200000); wr(1'b1, 32'h3e800000);
    rd(7'd95, v95, "R8 slot95 written");
    repeat (2) begin
      wr(1'b1, 32'h40400000); wr(1'b1, 32'h40400000); wr(1'b1, 32'h40400000); wr(1'b1, 32'h40400000);
    end
    rd(7'd95, v95, "R8 overflow dropped slot95");
    rd(7'd0,  '0,  "R8 no wrap slot0");
    setup(7'd110, 1'b0);
    wr(1'b1, 32'h12345678); wr(1'b1, 32'h12345678); wr(1'b1, 32'h12345678);
    rd(7'd95, v95, "R8 high setup dropped");

    // R11: out-of-range reads
    rd(7'd100, '0, "R11 read slot100");
    rd(7'd127, '0, "R11 read slot127");

    // R9: same-cycle write and read bypass
    setup(7'd60, 1'b0);
    wr(1'b1, 32'h0000aaaa); wr(1'b1, 32'h0000bbbb);
    wr_rd(32'h0000cccc, 7'd60, 96'h0000cccc_0000bbbb_0000aaaa, "R9 bypass slot60");
    rd(7'd60, 96'h0000cccc_0000bbbb_0000aaaa, "R9 stored slot60");

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule